// File: doc/BRIEF.md
# Hinted Two-Level Branch Predictor

This block sits in the fetch stage and turns each fetch address into a next-cycle prediction: whether the branch at that address is taken, where it goes, and which internal structure made the call. It combines three predictors.

The first is a small four-entry register file of branch/target pairs. Software loads it through a hint port, and it gives a taken prediction whenever the fetch address matches a stored branch. The second is a direction table of 512 two-bit saturating counters, organised as 128 sets of 4 ways. It is paired with a 64-entry direct-mapped target cache and trained by resolved-branch updates. The third is an eight-entry return stack: calls push onto it and returns pop from it.

The fetch unit presents the fetch address every cycle, together with call and return flags for that address. The registered prediction appears after the next clock edge. Every lookup sees the predictor state as it was before any write made in the same cycle.

Top module: `hinted_bpred`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, `pred_taken` is 0, `pred_src` is 0 and `pred_target` is 0.
- R2: The prediction for the inputs presented in a cycle is visible on the outputs after the next rising edge. A hint write, an update or a stack push made in the same cycle does not affect that prediction.
- R3: The hint store keeps 4 branch/target pairs. Each hint write fills the next slot in circular order, so the fifth write replaces the oldest pair. When several pairs match the fetch address, the most recently written pair supplies the target.
- R4: A match in the hint store gives `pred_taken`=1, `pred_src`=1 and the stored target. This source outranks every other source.
- R5: A call pushes `fetch_pc`+16 onto the return stack. A return with a non-empty stack predicts taken to the top entry with `pred_src`=2 (unless a hint matches) and pops that entry, whichever source wins. A return on an empty stack falls through to the table. A call and a return in the same cycle replace the top entry.
- R6: The return stack holds 8 entries. A push onto a full stack overwrites the oldest entry. After 8 pops the stack is empty.
- R7: The direction table is indexed by address bits [8:2] and tagged with bits [31:9]. An update that misses allocates the set's round-robin way with counter value 2 and then advances that set's pointer.
- R8: An update that hits its entry moves the counter up when the branch was taken and down when it was not, saturating at 0 and 3. A counter value of 2 or 3 predicts taken.
- R9: The target cache is direct-mapped, indexed by bits [7:2] and tagged with bits [31:8]. It is written only on taken updates. The table yields `pred_taken`=1 with `pred_src`=3 only when the direction counter predicts taken and the target cache hits.
- R10: When no source predicts taken, the outputs are `pred_taken`=0, `pred_src`=0 and `pred_target`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | ADDR_W | Address being fetched |
| fetch_call | input | 1 | Fetched branch is a call |
| fetch_ret | input | 1 | Fetched branch is a return |
| hint_we | input | 1 | Write a hint pair |
| hint_pc | input | ADDR_W | Branch address of the hint |
| hint_tgt | input | ADDR_W | Target of the hint |
| upd_valid | input | 1 | Resolved branch update |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_tgt | input | ADDR_W | Resolved target |
| pred_taken | output | 1 | Predicted taken |
| pred_target | output | ADDR_W | Predicted target |
| pred_src | output | 2 | 0 none, 1 hint, 2 return stack, 3 table |

## Verification
The interesting collision is a return that hits a non-empty stack in the same cycle that its address matches a hint pair, or in the same cycle as a call. In the first case the hint must win, yet the stack must still pop. In the second case the top entry must be replaced, not stacked. Directed sequences place hints on return addresses and issue call+return pairs. Random traffic over a small address pool then makes these cases and same-cycle updates common. The bench judges each cycle against a reference model that applies reads before writes, and the depth of the stack is checked by later returns.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_HINT  = 2'd1,
    SRC_RET   = 2'd2,
    SRC_TABLE = 2'd3
  } pred_src_e;

  function automatic logic [1:0] ctr_next(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    else    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

endpackage

// File: rtl/bp_hint_fifo.sv
module bp_hint_fifo #(
  parameter int AW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wr_pc,
  input  logic [AW-1:0] wr_tgt,
  input  logic [AW-1:0] look_pc,
  output logic          hit,
  output logic [AW-1:0] hit_tgt
);
  localparam int PW = $clog2(DEPTH);

  logic [DEPTH-1:0] vld;
  logic [PW-1:0]    wp;
  logic [AW-1:0]    pc_q  [DEPTH];
  logic [AW-1:0]    tgt_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      wp  <= '0;
    end else if (we) begin
      vld[wp] <= 1'b1;
      wp      <= wp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      pc_q[wp]  <= wr_pc;
      tgt_q[wp] <= wr_tgt;
    end
  end

  // walk from oldest to newest so the newest match wins
  always_comb begin
    logic [PW-1:0] idx;
    hit     = 1'b0;
    hit_tgt = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = wp + PW'(k);
      if (vld[idx] && pc_q[idx] == look_pc) begin
        hit     = 1'b1;
        hit_tgt = tgt_q[idx];
      end
    end
  end
endmodule

// File: rtl/bp_dir_table.sv
module bp_dir_table import bp_pkg::*; #(
  parameter int AW   = 32,
  parameter int SETS = 128,
  parameter int WAYS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] look_pc,
  output logic          look_taken,
  input  logic          upd_valid,
  input  logic [AW-1:0] upd_pc,
  input  logic          upd_taken
);
  localparam int IW = $clog2(SETS);
  localparam int TW = AW - 2 - IW;
  localparam int WW = $clog2(WAYS);

  logic [IW-1:0] ls, us;
  logic [TW-1:0] lt, ut;
  assign ls = look_pc[2 +: IW];
  assign lt = look_pc[AW-1 -: TW];
  assign us = upd_pc[2 +: IW];
  assign ut = upd_pc[AW-1 -: TW];

  logic [WAYS-1:0] vld [SETS];
  logic [WW-1:0]   rr  [SETS];
  logic [WAYS-1:0] l_tk, u_hit;
  logic            u_any;

  assign u_any      = |u_hit;
  assign look_taken = |l_tk;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TW-1:0] tag_mem [SETS];
    logic [1:0]    ctr_mem [SETS];
    logic          wsel;

    assign l_tk[w]  = vld[ls][w] && tag_mem[ls] == lt && ctr_mem[ls][1];
    assign u_hit[w] = vld[us][w] && tag_mem[us] == ut;
    assign wsel     = upd_valid && (u_hit[w] || (!u_any && rr[us] == WW'(w)));

    always_ff @(posedge clk) begin
      if (wsel) begin
        tag_mem[us] <= ut;
        ctr_mem[us] <= u_hit[w] ? ctr_next(ctr_mem[us], upd_taken) : 2'd2;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        rr[s]  <= '0;
      end
    end else if (upd_valid && !u_any) begin
      vld[us][rr[us]] <= 1'b1;
      rr[us]          <= rr[us] + 1'b1;
    end
  end
endmodule

// File: rtl/bp_tgt_cache.sv
module bp_tgt_cache #(
  parameter int AW      = 32,
  parameter int ENTRIES = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] look_pc,
  output logic          look_hit,
  output logic [AW-1:0] look_tgt,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_pc,
  input  logic [AW-1:0] wr_tgt
);
  localparam int IW = $clog2(ENTRIES);
  localparam int TW = AW - 2 - IW;

  logic [ENTRIES-1:0] vld;
  logic [TW-1:0]      tag_mem [ENTRIES];
  logic [AW-1:0]      tgt_mem [ENTRIES];
  logic [IW-1:0]      li, wi;

  assign li = look_pc[2 +: IW];
  assign wi = wr_pc[2 +: IW];

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (wr_en) vld[wi] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wi] <= wr_pc[AW-1 -: TW];
      tgt_mem[wi] <= wr_tgt;
    end
  end

  assign look_hit = vld[li] && tag_mem[li] == look_pc[AW-1 -: TW];
  assign look_tgt = tgt_mem[li];
endmodule

// File: rtl/bp_ret_stack.sv
module bp_ret_stack #(
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_val,
  input  logic          pop,
  output logic          top_valid,
  output logic [AW-1:0] top_val
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] tp;
  logic [CW-1:0] cnt;
  logic [AW-1:0] mem [DEPTH];
  logic          do_pop;
  logic [PW-1:0] tp_m1;

  assign tp_m1     = tp - 1'b1;
  assign do_pop    = pop && cnt != '0;
  assign top_valid = cnt != '0;
  assign top_val   = mem[tp_m1];

  always_ff @(posedge clk) begin
    if (rst) begin
      tp  <= '0;
      cnt <= '0;
    end else begin
      case ({push, do_pop})
        2'b10: begin
          tp  <= tp + 1'b1;
          cnt <= (cnt == CW'(DEPTH)) ? cnt : cnt + 1'b1;
        end
        2'b01: begin
          tp  <= tp_m1;
          cnt <= cnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      if (do_pop) mem[tp_m1] <= push_val;
      else        mem[tp]    <= push_val;
    end
  end
endmodule

// File: rtl/hinted_bpred.sv
module hinted_bpred import bp_pkg::*; #(
  parameter int ADDR_W      = 32,
  parameter int HINT_DEPTH  = 4,
  parameter int SETS        = 128,
  parameter int WAYS        = 4,
  parameter int TGT_ENTRIES = 64,
  parameter int RS_DEPTH    = 8,
  parameter int FALL_BYTES  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              fetch_call,
  input  logic              fetch_ret,
  input  logic              hint_we,
  input  logic [ADDR_W-1:0] hint_pc,
  input  logic [ADDR_W-1:0] hint_tgt,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_tgt,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_target,
  output logic [1:0]        pred_src
);
  logic              hint_hit, dir_taken, btc_hit, rs_valid, tbl_taken;
  logic [ADDR_W-1:0] hint_t, btc_t, rs_top;

  bp_hint_fifo #(.AW(ADDR_W), .DEPTH(HINT_DEPTH)) u_hint (
    .clk(clk), .rst(rst), .we(hint_we), .wr_pc(hint_pc), .wr_tgt(hint_tgt),
    .look_pc(fetch_pc), .hit(hint_hit), .hit_tgt(hint_t));

  bp_dir_table #(.AW(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u_dir (
    .clk(clk), .rst(rst), .look_pc(fetch_pc), .look_taken(dir_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  bp_tgt_cache #(.AW(ADDR_W), .ENTRIES(TGT_ENTRIES)) u_btc (
    .clk(clk), .rst(rst), .look_pc(fetch_pc), .look_hit(btc_hit), .look_tgt(btc_t),
    .wr_en(upd_valid && upd_taken), .wr_pc(upd_pc), .wr_tgt(upd_tgt));

  bp_ret_stack #(.AW(ADDR_W), .DEPTH(RS_DEPTH)) u_rs (
    .clk(clk), .rst(rst), .push(fetch_call),
    .push_val(fetch_pc + ADDR_W'(FALL_BYTES)), .pop(fetch_ret),
    .top_valid(rs_valid), .top_val(rs_top));

  assign tbl_taken = dir_taken && btc_hit;

  pred_src_e         nxt_src;
  logic [ADDR_W-1:0] nxt_tgt;

  always_comb begin
    if (hint_hit) begin
      nxt_src = SRC_HINT;  nxt_tgt = hint_t;
    end else if (fetch_ret && rs_valid) begin
      nxt_src = SRC_RET;   nxt_tgt = rs_top;
    end else if (tbl_taken) begin
      nxt_src = SRC_TABLE; nxt_tgt = btc_t;
    end else begin
      nxt_src = SRC_NONE;  nxt_tgt = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_taken  <= 1'b0;
      pred_target <= '0;
      pred_src    <= 2'd0;
    end else begin
      pred_taken  <= nxt_src != SRC_NONE;
      pred_target <= nxt_tgt;
      pred_src    <= nxt_src;
    end
  end
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          hint_hit,
  input logic          fetch_ret,
  input logic          rs_valid,
  input logic          tbl_taken,
  input logic          pred_taken,
  input logic [AW-1:0] pred_target,
  input logic [1:0]    pred_src
);
  // R4: a hint match wins on the next cycle
  assert_hint_first_R4: assert property (@(posedge clk) disable iff (rst)
    hint_hit |=> pred_src == 2'd1);

  // R5: a return with a live stack and no hint uses the stack
  assert_ret_second_R5: assert property (@(posedge clk) disable iff (rst)
    (!hint_hit && fetch_ret && rs_valid) |=> pred_src == 2'd2);

  // R10: nothing predicting leads to the fall-through outputs
  assert_no_source_R10: assert property (@(posedge clk) disable iff (rst)
    (!hint_hit && !(fetch_ret && rs_valid) && !tbl_taken) |=> (pred_src == 2'd0 && !pred_taken));

  // R10: taken flag and source code agree
  assert_taken_matches_src_R10: assert property (@(posedge clk) disable iff (rst)
    pred_taken == (pred_src != 2'd0));

  // R10: no target is offered without a source
  assert_zero_target_R10: assert property (@(posedge clk) disable iff (rst)
    pred_src == 2'd0 |-> pred_target == '0);
endmodule

bind hinted_bpred bp_checker #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .hint_hit(hint_hit), .fetch_ret(fetch_ret),
  .rs_valid(rs_valid), .tbl_taken(tbl_taken), .pred_taken(pred_taken),
  .pred_target(pred_target), .pred_src(pred_src));

// File: tb/hinted_bpred_tb.sv
module hinted_bpred_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_pc = '0, hint_pc = '0, hint_tgt = '0, upd_pc = '0, upd_tgt = '0;
  logic        fetch_call = 0, fetch_ret = 0, hint_we = 0, upd_valid = 0, upd_taken = 0;
  logic        pred_taken;
  logic [31:0] pred_target;
  logic [1:0]  pred_src;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hinted_bpred u_dut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .fetch_call(fetch_call),
    .fetch_ret(fetch_ret), .hint_we(hint_we), .hint_pc(hint_pc), .hint_tgt(hint_tgt),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_tgt(upd_tgt),
    .pred_taken(pred_taken), .pred_target(pred_target), .pred_src(pred_src));

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  bit          h_v [4];
  logic [31:0] h_pc [4], h_tg [4];
  int          h_wp;
  bit          m_v [128][4];
  logic [22:0] m_tag [128][4];
  int          m_ctr [128][4];
  int          m_rr [128];
  bit          b_v [64];
  logic [23:0] b_tag [64];
  logic [31:0] b_tg [64];
  logic [31:0] r_mem [8];
  int          r_tp, r_cnt;

  bit          pend = 0;
  bit          e_tk;
  logic [31:0] e_tg;
  int          e_src;

  function automatic void model_reset();
    h_wp = 0; r_tp = 0; r_cnt = 0;
    for (int i = 0; i < 4; i++) h_v[i] = 0;
    for (int s = 0; s < 128; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 4; w++) m_v[s][w] = 0;
    end
    for (int i = 0; i < 64; i++) b_v[i] = 0;
  endfunction

  function automatic int sat(input int c, input bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic check(input string req, input bit tk, input logic [31:0] tg, input int src);
    checks++;
    if (pred_taken !== tk || pred_target !== tg || int'(pred_src) != src) begin
      fails++;
      $display("FAIL %s: got taken=%0b tgt=%h src=%0d, expected taken=%0b tgt=%h src=%0d",
               req, pred_taken, pred_target, pred_src, tk, tg, src);
    end
  endtask

  task automatic step(input logic [31:0] pc, input bit call, input bit ret,
                      input bit hw, input logic [31:0] hpc, input logic [31:0] htg,
                      input bit uv, input logic [31:0] upc, input bit ut, input logic [31:0] utg);
    bit hh, dt, bh, pop;
    logic [31:0] ht, fall;
    int s, b, us, hitw;
    @(negedge clk);
    if (pend) check(cur_req, e_tk, e_tg, e_src);
    fetch_pc = pc; fetch_call = call; fetch_ret = ret;
    hint_we = hw; hint_pc = hpc; hint_tgt = htg;
    upd_valid = uv; upd_pc = upd_pc; upd_pc = upc; upd_taken = ut; upd_tgt = utg;
    // expected prediction from state before this cycle's writes (R2)
    hh = 0; ht = '0;
    for (int k = 0; k < 4; k++) begin
      int idx;
      idx = (h_wp + k) % 4;
      if (h_v[idx] && h_pc[idx] == pc) begin hh = 1; ht = h_tg[idx]; end
    end
    s = int'(pc[8:2]); dt = 0;
    for (int w = 0; w < 4; w++)
      if (m_v[s][w] && m_tag[s][w] == pc[31:9] && m_ctr[s][w] >= 2) dt = 1;
    b = int'(pc[7:2]);
    bh = b_v[b] && b_tag[b] == pc[31:8];
    if (hh)                     begin e_src = 1; e_tg = ht; end
    else if (ret && r_cnt != 0) begin e_src = 2; e_tg = r_mem[(r_tp + 7) % 8]; end
    else if (dt && bh)          begin e_src = 3; e_tg = b_tg[b]; end
    else                        begin e_src = 0; e_tg = '0; end
    e_tk = (e_src != 0);
    pend = 1;
    // model writes
    if (hw) begin
      h_v[h_wp] = 1; h_pc[h_wp] = hpc; h_tg[h_wp] = htg; h_wp = (h_wp + 1) % 4;
    end
    if (uv) begin
      us = int'(upc[8:2]); hitw = -1;
      for (int w = 0; w < 4; w++)
        if (m_v[us][w] && m_tag[us][w] == upc[31:9]) hitw = w;
      if (hitw >= 0) m_ctr[us][hitw] = sat(m_ctr[us][hitw], ut);
      else begin
        m_v[us][m_rr[us]] = 1; m_tag[us][m_rr[us]] = upc[31:9];
        m_ctr[us][m_rr[us]] = 2; m_rr[us] = (m_rr[us] + 1) % 4;
      end
      if (ut) begin
        b_v[upc[7:2]] = 1; b_tag[upc[7:2]] = upc[31:8]; b_tg[upc[7:2]] = utg;
      end
    end
    pop = ret && r_cnt != 0;
    fall = pc + 32'd16;
    if (call && pop) r_mem[(r_tp + 7) % 8] = fall;
    else if (call) begin
      r_mem[r_tp] = fall; r_tp = (r_tp + 1) % 8;
      if (r_cnt < 8) r_cnt++;
    end else if (pop) begin
      r_tp = (r_tp + 7) % 8; r_cnt--;
    end
  endtask

  task automatic fetch(input logic [31:0] pc);
    step(pc, 0, 0, 0, '0, '0, 0, '0, 0, '0);
  endtask
  task automatic hint(input logic [31:0] pc, input logic [31:0] hpc, input logic [31:0] htg);
    step(pc, 0, 0, 1, hpc, htg, 0, '0, 0, '0);
  endtask
  task automatic upd(input logic [31:0] pc, input logic [31:0] upc, input bit ut, input logic [31:0] utg);
    step(pc, 0, 0, 0, '0, '0, 1, upc, ut, utg);
  endtask

  function automatic logic [31:0] rpc();
    return 32'h4000_0000 | (($urandom % 4) << 9) | (($urandom % 4) << 2);
  endfunction

  initial begin
    repeat (CLK_PERIOD * 0 + 200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: got running, expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] p;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1 check("R1 (in reset)", 0, '0, 0);
    @(negedge clk); rst = 0;
    check("R1", 0, '0, 0);

    // R3 / R4: five hints evict the oldest; R2: same-cycle write not seen
    cur_req = "R3";
    for (int i = 0; i < 5; i++) hint(32'h0, 32'h100 + 32'(i) * 4, 32'hA000 + 32'(i));
    for (int i = 0; i < 5; i++) fetch(32'h100 + 32'(i) * 4);
    hint(32'h0, 32'h108, 32'hBEEF);           // duplicate: newest wins
    fetch(32'h108);
    cur_req = "R2";
    hint(32'h200, 32'h200, 32'hC0DE);         // write and look up same address
    fetch(32'h200);

    // R8: counter walk with target present
    cur_req = "R8";
    p = 32'h8000_0040;
    upd(p, p, 1, 32'h1234);                   // allocate at 2, target cached
    fetch(p);
    upd(p, p, 0, '0); fetch(p);               // 1: not taken
    upd(p, p, 0, '0); upd(p, p, 0, '0); fetch(p); // 0 saturates
    upd(p, p, 1, 32'h1234); fetch(p);         // 1
    upd(p, p, 1, 32'h1234); fetch(p);         // 2: taken
    for (int i = 0; i < 4; i++) upd(p, p, 1, 32'h1234);
    upd(p, p, 0, '0); fetch(p);               // 3 then 2: still taken

    // R7: five tags in one set, round-robin replacement
    cur_req = "R7";
    for (int i = 0; i < 5; i++) upd(32'h0, 32'h0000_0080 + (32'(i) << 9), 1, 32'h7700 + 32'(i));
    for (int i = 0; i < 5; i++) fetch(32'h0000_0080 + (32'(i) << 9));

    // R9: direction says taken but no cached target
    cur_req = "R9";
    upd(32'h0, 32'h0003_0010, 0, '0);         // allocates at 2, no target write
    fetch(32'h0003_0010);

    // R5 / R6: nine calls, ten returns
    cur_req = "R6";
    for (int i = 0; i < 9; i++) step(32'h5000 + 32'(i) * 32, 1, 0, 0, '0, '0, 0, '0, 0, '0);
    for (int i = 0; i < 10; i++) step(32'h9000, 0, 1, 0, '0, '0, 0, '0, 0, '0);
    cur_req = "R5";
    step(32'h6000, 1, 0, 0, '0, '0, 0, '0, 0, '0);
    step(32'h6100, 1, 1, 0, '0, '0, 0, '0, 0, '0); // replace top
    hint(32'h0, 32'h9000, 32'hFACE);
    step(32'h9000, 0, 1, 0, '0, '0, 0, '0, 0, '0); // hint wins, stack pops
    step(32'h9004, 0, 1, 0, '0, '0, 0, '0, 0, '0); // stack now empty
    fetch(32'h0);

    // random traffic; R10 covers every not-taken outcome
    cur_req = "R10 (random)";
    for (int i = 0; i < 4000; i++) begin
      p = rpc();
      step(p, ($urandom % 6) == 0, ($urandom % 5) == 0,
           ($urandom % 9) == 0, rpc(), $urandom,
           ($urandom % 2) == 0, rpc(), ($urandom % 3) != 0, $urandom);
    end
    fetch(32'h0);
    @(negedge clk);
    check(cur_req, e_tk, e_tg, e_src);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule